// File: doc/BRIEF.md
# SRAM Self-Test with Spare-Word Remapping

This block wraps a small single-port SRAM model with a built-in self-test and a repair stage. When reset is released it runs a march test over every address without any outside command. Each address whose read-back differs from the expected pattern is entered into a small table of spare words. When the test has finished, the user port is opened. An access to an address held in the table goes to that address's spare word and not to the array. The steering is done by multiplexers on the address, write-data and read-data paths, outside the array itself.

The array model takes stuck-at faults on data bit 0 from two parameter bitmaps. A parameter bitmap is used because a real array's static, repeatable cell defects cannot be set from outside. The list of remapped addresses is brought out as a signature, so that runs under different test conditions can be compared. Faults that appear only after the test are outside the scope of this block.

Top module: `sram_bist_remap`

## Requirements
- R1: The test starts by itself when rst_n is released. `done` rises after exactly 4*DEPTH clock cycles. `ready` stays low until `done` is high and then stays high.
- R2: The march runs four passes:
  - write all-zero, ascending;
  - read expecting zero, then write all-one, ascending;
  - read expecting all-one, then write zero, descending;
  - read expecting zero, ascending.

  Table entries are therefore filled in order of detection: stuck-at-1 addresses in ascending order, then stuck-at-0 addresses in descending order. Entry k appears in `sig_addr[k*AW +: AW]`, and `sig_vld[k]` marks it as used.
- R3: Once `done` is high, a write (`u_req` and `u_we` high) to a recorded address stores the data in its spare word. The combinational `u_rdata` returns that data on later reads, including after the spare word is overwritten.
- R4: An address that is not recorded reads from the array. A stuck-at-1 cell forces bit 0 to 1, and a stuck-at-0 cell forces bit 0 to 0.
- R5: At most SPARES entries are recorded. If one more distinct address fails, `repairable` goes low and `pass` stays low.
- R6: With at most SPARES failing addresses, `repairable` stays high and `pass` rises together with `done`.
- R7: An address that fails in more than one pass takes only one table entry.
- R8: During reset, `done`, `ready` and `pass` are low and `sig_vld` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the test starts when it is released |
| u_req | input | 1 | User access request |
| u_we | input | 1 | Write enable for the user access |
| u_addr | input | AW | User address |
| u_wdata | input | WIDTH | User write data |
| u_rdata | output | WIDTH | Read data for `u_addr`, from a spare word or from the array |
| ready | output | 1 | The user port is open |
| done | output | 1 | The self-test has completed |
| pass | output | 1 | Test complete and every failing address has been remapped |
| repairable | output | 1 | The number of failing addresses fits in the spare table |
| sig_addr | output | SPARES*AW | Repair signature: the recorded addresses |
| sig_vld | output | SPARES | Valid flag for each signature entry |

## Verification
Two things can happen in the same cycle: an address that is already in the table is read again during the final pass, and the failure recorder decides whether to take a new entry. One instance has two stuck-at-1 cells, which fail in both the second and the fourth pass. The bench checks that the signature lists each of those addresses only once. A second instance has five failing cells, so the recorder finds the table full in the same cycle as a new failure. That instance is judged on its four-entry signature, on `repairable` going low, and on the fifth address still showing its fault after an exhaustive write-and-read sweep.

// File: rtl/sram_bist_remap.sv
module sram_bist_remap #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int SPARES = 4,
  parameter logic [DEPTH-1:0] STUCK1_MAP = '0,
  parameter logic [DEPTH-1:0] STUCK0_MAP = '0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   u_req,
  input  logic                   u_we,
  input  logic [AW-1:0]          u_addr,
  input  logic [WIDTH-1:0]       u_wdata,
  output logic [WIDTH-1:0]       u_rdata,
  output logic                   ready,
  output logic                   done,
  output logic                   pass,
  output logic                   repairable,
  output logic [SPARES*AW-1:0]   sig_addr,
  output logic [SPARES-1:0]      sig_vld
);
  localparam int SW = (SPARES > 1) ? $clog2(SPARES) : 1;
  localparam logic [SW:0]   NSP = SW'(SPARES) | (SW+1)'(SPARES);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem     [DEPTH];
  logic [WIDTH-1:0] spare_q [SPARES];
  logic [AW-1:0]    tag_q   [SPARES];
  logic [SPARES-1:0] vld_q;
  logic [SW:0]       cnt_q;
  logic              ovf_q, done_q;
  logic [1:0]        ph_q;
  logic [AW-1:0]     ta_q;

  logic [AW-1:0]     look_addr;
  logic [SPARES-1:0] hit_vec;
  logic [SW-1:0]     hit_idx;
  logic              hit;
  logic [WIDTH-1:0]  cell_rd, expv;
  logic              t_fail, t_new, last;
  logic              u_wr;

  assign look_addr = done_q ? u_addr : ta_q;

  for (genvar k = 0; k < SPARES; k++) begin : g_cmp
    assign hit_vec[k] = vld_q[k] && (tag_q[k] == look_addr);
    assign sig_addr[k*AW +: AW] = tag_q[k];
  end

  always_comb begin
    hit_idx = '0;
    for (int k = 0; k < SPARES; k++)
      if (hit_vec[k]) hit_idx = SW'(k);
  end
  assign hit = |hit_vec;

  always_comb begin
    cell_rd = mem[look_addr];
    if (STUCK1_MAP[look_addr]) cell_rd[0] = 1'b1;
    if (STUCK0_MAP[look_addr]) cell_rd[0] = 1'b0;
  end

  assign expv   = (ph_q == 2'd2) ? '1 : '0;
  assign t_fail = !done_q && (ph_q != 2'd0) && (cell_rd != expv);
  assign t_new  = t_fail && !hit;
  assign last   = (ph_q == 2'd2) ? (ta_q == '0) : (ta_q == TOP);
  assign u_wr   = done_q && u_req && u_we;

  assign u_rdata    = (done_q && hit) ? spare_q[hit_idx] : cell_rd;
  assign ready      = done_q;
  assign done       = done_q;
  assign repairable = !ovf_q;
  assign pass       = done_q && !ovf_q;
  assign sig_vld    = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 2'd0;
      ta_q   <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (last) begin
        ph_q <= ph_q + 2'd1;
        ta_q <= (ph_q == 2'd1) ? TOP : '0;
        if (ph_q == 2'd3) done_q <= 1'b1;
      end else if (ph_q == 2'd2) begin
        ta_q <= ta_q - 1'b1;
      end else begin
        ta_q <= ta_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!done_q && rst_n && ph_q != 2'd3)
      mem[ta_q] <= (ph_q == 2'd1) ? '1 : '0;
    else if (u_wr && !hit)
      mem[u_addr] <= u_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      for (int k = 0; k < SPARES; k++) tag_q[k] <= '0;
    end else if (t_new) begin
      if (cnt_q < NSP) begin
        tag_q[cnt_q[SW-1:0]] <= ta_q;
        vld_q[cnt_q[SW-1:0]] <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SPARES; k++) spare_q[k] <= '0;
    end else if (u_wr && hit) begin
      spare_q[hit_idx] <= u_wdata;
    end
  end

  p_done_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  p_done_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(ph_q) == 2'd3 && $past(ta_q) == TOP));
  p_table_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= SPARES);
  p_ovf_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (cnt_q == NSP));
  p_vld_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));
  p_single_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: tb/sram_bist_remap_bench.sv
module sram_bist_remap_bench;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 16;
  localparam int WIDTH  = 8;
  localparam int SPARES = 4;
  localparam int AW     = 4;
  localparam logic [DEPTH-1:0] B_S1 = 16'h0204;
  localparam logic [DEPTH-1:0] B_S0 = 16'h4020;
  localparam logic [DEPTH-1:0] C_S1 = 16'h0089;
  localparam logic [DEPTH-1:0] C_S0 = 16'h8002;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic u_req = 1'b0, u_we = 1'b0;
  logic [AW-1:0] u_addr = '0;
  logic [WIDTH-1:0] u_wdata = '0;
  logic [WIDTH-1:0] rd [3];
  logic rdy [3], dn [3], ps [3], rp [3];
  logic [SPARES*AW-1:0] sa [3];
  logic [SPARES-1:0] sv [3];

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sram_bist_remap u_sram_bist_remap (
    .clk(clk), .rst_n(rst_n), .u_req(u_req), .u_we(u_we), .u_addr(u_addr),
    .u_wdata(u_wdata), .u_rdata(rd[0]), .ready(rdy[0]), .done(dn[0]),
    .pass(ps[0]), .repairable(rp[0]), .sig_addr(sa[0]), .sig_vld(sv[0]));

  sram_bist_remap #(.STUCK1_MAP(B_S1), .STUCK0_MAP(B_S0)) u_sram_bist_remap_fix (
    .clk(clk), .rst_n(rst_n), .u_req(u_req), .u_we(u_we), .u_addr(u_addr),
    .u_wdata(u_wdata), .u_rdata(rd[1]), .ready(rdy[1]), .done(dn[1]),
    .pass(ps[1]), .repairable(rp[1]), .sig_addr(sa[1]), .sig_vld(sv[1]));

  sram_bist_remap #(.STUCK1_MAP(C_S1), .STUCK0_MAP(C_S0)) u_sram_bist_remap_ovf (
    .clk(clk), .rst_n(rst_n), .u_req(u_req), .u_we(u_we), .u_addr(u_addr),
    .u_wdata(u_wdata), .u_rdata(rd[2]), .ready(rdy[2]), .done(dn[2]),
    .pass(ps[2]), .repairable(rp[2]), .sig_addr(sa[2]), .sig_vld(sv[2]));

  logic [DEPTH-1:0] s1m [3];
  logic [DEPTH-1:0] s0m [3];
  int  etag [3][SPARES];
  int  en [3];
  bit  eovf [3];

  task automatic chk(input string req, input int inst, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s inst%0d actual=%0h expected=%0h", req, inst, act, exp);
    end
  endtask

  task automatic add_fail(input int i, input int a);
    bit seen = 1'b0;
    for (int k = 0; k < en[i]; k++) if (etag[i][k] == a) seen = 1'b1;
    if (!seen) begin
      if (en[i] < SPARES) begin etag[i][en[i]] = a; en[i]++; end
      else eovf[i] = 1'b1;
    end
  endtask

  function automatic bit is_rep(input int i, input int a);
    for (int k = 0; k < en[i]; k++) if (etag[i][k] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [WIDTH-1:0] exp_rd(input int i, input int a,
                                              input logic [WIDTH-1:0] d);
    logic [WIDTH-1:0] v = d;
    if (!is_rep(i, a)) begin
      if (s1m[i][a]) v[0] = 1'b1;
      if (s0m[i][a]) v[0] = 1'b0;
    end
    return v;
  endfunction

  task automatic sweep(input int mul, input int add);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      u_req = 1'b1; u_we = 1'b1; u_addr = AW'(a); u_wdata = WIDTH'(a*mul + add);
    end
    @(negedge clk);
    u_we = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      u_addr = AW'(a);
      #1;
      for (int i = 0; i < 3; i++) begin
        logic [WIDTH-1:0] d = WIDTH'(a*mul + add);
        if (is_rep(i, a))
          chk("R3 spare data", i, 32'(rd[i]), 32'(exp_rd(i, a, d)));
        else
          chk("R4 array data", i, 32'(rd[i]), 32'(exp_rd(i, a, d)));
      end
      @(negedge clk);
    end
    u_req = 1'b0;
  endtask

  initial begin
    int n;
    s1m[0] = '0;   s0m[0] = '0;
    s1m[1] = B_S1; s0m[1] = B_S0;
    s1m[2] = C_S1; s0m[2] = C_S0;
    for (int i = 0; i < 3; i++) begin
      en[i] = 0; eovf[i] = 1'b0;
      for (int a = 0; a < DEPTH; a++) if (s1m[i][a]) add_fail(i, a);
      for (int a = DEPTH-1; a >= 0; a--) if (s0m[i][a]) add_fail(i, a);
      for (int a = 0; a < DEPTH; a++) if (s1m[i][a]) add_fail(i, a);
    end

    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R8 done in reset", i, 32'(dn[i]), 0);
      chk("R8 ready in reset", i, 32'(rdy[i]), 0);
      chk("R8 pass in reset", i, 32'(ps[i]), 0);
      chk("R8 sig_vld in reset", i, 32'(sv[i]), 0);
    end

    rst_n = 1'b1;
    n = 0;
    while (!dn[0] && n < 1000) begin
      @(negedge clk);
      n++;
      if (n == 10)
        for (int i = 0; i < 3; i++) chk("R1 ready low during test", i, 32'(rdy[i]), 0);
    end
    chk("R1 test length", 0, 32'(n), 32'(4*DEPTH));
    for (int i = 0; i < 3; i++) begin
      chk("R1 done", i, 32'(dn[i]), 1);
      chk("R1 ready after test", i, 32'(rdy[i]), 1);
      chk("R5 repairable", i, 32'(rp[i]), 32'(!eovf[i]));
      if (eovf[i]) chk("R5 pass low on overflow", i, 32'(ps[i]), 0);
      else         chk("R6 pass", i, 32'(ps[i]), 1);
      chk("R7 entry count", i, 32'($countones(sv[i])), 32'(en[i]));
      for (int k = 0; k < en[i]; k++)
        chk("R2 signature entry", i, 32'(sa[i][k*AW +: AW]), 32'(etag[i][k]));
    end

    sweep(37, 11);
    sweep(91, 200);
    for (int i = 0; i < 3; i++) chk("R1 ready stays high", i, 32'(rdy[i]), 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule